// File: doc/BRIEF.md
# Interrupt File Indirect Register Access Unit

This block holds a bank of interrupt files, one file per page, and serves indirectly selected register accesses to them. Each interrupt file keeps a pending bit and an enable bit per identity, a one-bit delivery switch and a threshold. A request names the privilege level, whether the access comes from a virtualized context, a guest-select index, an 8-bit register select, the access width and a write value with a write mask.

The unit checks that the access is legal for the configured mode, picks the target page, and returns the register's previous value. It then applies the masked write to the delivery switch, the threshold, the pending or enable words, or the top-interrupt register. Reading the top-interrupt register reports the lowest enabled and pending identity that the threshold allows. Writing it with a nonzero mask claims that identity. Illegal accesses are answered with an error flag and leave every file untouched.

The configuration mode, machine or supervisor, is a static input that is captured while reset is held. The page count is a parameter from 1 to 64. `NIDS` is the number of identity slots per page, a multiple of 64, and slot 0 is reserved.

Top module: `irf_indirect_access`

## Requirements
- R1: In machine mode (`mode_m_i` high at reset), only an access with privilege 3 and `req_virt_i` low is legal, and it targets page 0. Every other access returns an error.
- R2: In supervisor mode, privilege 1 with `req_virt_i` low targets page 0. Privilege 1 with `req_virt_i` high targets page `req_gsel_i`, which must be nonzero and below `NPAGES`. Every other privilege or guest index returns an error.
- R3: Select 0x70 is the delivery switch, 0x72 the threshold, 0x7F the top-interrupt register, 0x80+n pending word n and 0xC0+n enable word n for n in 0..63. Any other select returns an error.
- R4: When `req_wide_i` is high, an odd n returns an error, and the word number is n/2 of 64 bits. Otherwise the word number is n of 32 bits. A word number at or above `NIDS`/width returns an error.
- R5: A word read returns in bit i the state of identity word*width + i. For 32-bit accesses, bits 63:32 read as zero.
- R6: A word write sets each bit whose write-mask bit is set to the matching write-data bit. Only mask bits 31:0 apply for 32-bit accesses. Identity 0 is never set and always reads 0.
- R7: The delivery switch stores write-data bit 0 when mask bit 0 is set. The threshold stores `THR_W` bits under the mask, and its upper bits read as zero.
- R8: A top-interrupt read returns (id << 16) | id for the lowest identity id ≥ 1 that is both pending and enabled and, when the threshold t is nonzero, satisfies id < t. If no identity qualifies, it returns 0.
- R9: A top-interrupt access with a nonzero write mask clears the pending bit of the identity it reports. It returns the value from before the clear.
- R10: `rsp_valid_o` rises in the cycle after each `req_valid_i` cycle. Each response carries the pre-write value. An error response carries zero data and changes no state.
- R11: Reset clears every pending bit, enable bit, delivery switch and threshold, and leaves `rsp_valid_o` and `rsp_err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_m_i | input | 1 | Machine-mode configuration, captured during reset |
| req_valid_i | input | 1 | Request strobe |
| req_priv_i | input | 2 | Privilege level of the access (3 machine, 1 supervisor, 0 user) |
| req_virt_i | input | 1 | Access comes from a virtualized context |
| req_gsel_i | input | 6 | Guest page index for virtualized accesses |
| req_sel_i | input | 8 | Register select |
| req_wide_i | input | 1 | 64-bit access when high, 32-bit when low |
| req_wdata_i | input | 64 | Write data |
| req_wmask_i | input | 64 | Write mask |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 64 | Previous register value |
| rsp_err_o | output | 1 | Access was illegal |

## Verification
The bench goes after the edges of page selection. It issues a guest index of zero and one equal to the page count, which a design with an off-by-one compare would accept. It also issues machine-privilege accesses in supervisor mode and the reverse, which a design that ignored the captured mode would serve. Odd word indices in 64-bit mode and word numbers one past the end must be refused; a design that forgot to halve or to bound the index would corrupt a neighbouring word or read out of range. Writes of all ones to word 0 expose a design that lets identity 0 become pending. Threshold values just at and above a pending identity, followed by a claim, expose an inclusive compare or a claim that clears the wrong bit. A rejected write followed by a read-back shows whether an illegal access leaked into state.

// File: rtl/irf_indirect_access.sv
module irf_indirect_access #(
  parameter int NPAGES = 4,
  parameter int NIDS   = 128,
  parameter int THR_W  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_m_i,
  input  logic        req_valid_i,
  input  logic [1:0]  req_priv_i,
  input  logic        req_virt_i,
  input  logic [5:0]  req_gsel_i,
  input  logic [7:0]  req_sel_i,
  input  logic        req_wide_i,
  input  logic [63:0] req_wdata_i,
  input  logic [63:0] req_wmask_i,
  output logic        rsp_valid_o,
  output logic [63:0] rsp_rdata_o,
  output logic        rsp_err_o
);
  localparam int PW      = (NPAGES > 1) ? $clog2(NPAGES) : 1;
  localparam int IDW     = $clog2(NIDS);
  localparam int N32     = NIDS / 32;
  localparam int N64     = NIDS / 64;
  localparam logic [7:0] SEL_DELIV = 8'h70;
  localparam logic [7:0] SEL_THR   = 8'h72;
  localparam logic [7:0] SEL_TOP   = 8'h7F;

  logic              mode_m_q;
  logic [NIDS-1:0]   pend_q [NPAGES];
  logic [NIDS-1:0]   en_q   [NPAGES];
  logic [NPAGES-1:0] deliv_q;
  logic [THR_W-1:0]  thr_q  [NPAGES];

  logic          page_ok;
  logic [PW-1:0] page;

  always_comb begin
    page_ok = 1'b0;
    page    = '0;
    if (mode_m_q) begin
      page_ok = (req_priv_i == 2'd3) && !req_virt_i;
    end else if (req_priv_i == 2'd1) begin
      if (!req_virt_i) begin
        page_ok = 1'b1;
      end else if (req_gsel_i != 6'd0 && {1'b0, req_gsel_i} < 7'(NPAGES)) begin
        page_ok = 1'b1;
        page    = PW'(req_gsel_i);
      end
    end
  end

  wire is_deliv = req_sel_i == SEL_DELIV;
  wire is_thr   = req_sel_i == SEL_THR;
  wire is_top   = req_sel_i == SEL_TOP;
  wire is_pend  = req_sel_i[7:6] == 2'b10;
  wire is_en    = req_sel_i[7:6] == 2'b11;

  wire [5:0] widx    = req_sel_i[5:0];
  wire [5:0] wnum    = req_wide_i ? {1'b0, widx[5:1]} : widx;
  wire       word_ok = req_wide_i ? (!widx[0] && 32'(wnum) < N64) : (32'(wnum) < N32);
  wire       sel_ok  = is_deliv | is_thr | is_top | ((is_pend | is_en) & word_ok);
  wire       acc_ok  = page_ok & sel_ok;

  wire [NIDS-1:0]  cur_pend = pend_q[page];
  wire [NIDS-1:0]  cur_en   = en_q[page];
  wire [THR_W-1:0] cur_thr  = thr_q[page];

  logic           top_hit;
  logic [IDW-1:0] top_id;

  always_comb begin
    top_hit = 1'b0;
    top_id  = '0;
    for (int i = NIDS - 1; i >= 1; i--) begin
      if (cur_pend[i] && cur_en[i] && (cur_thr == '0 || 32'(i) < 32'(cur_thr))) begin
        top_hit = 1'b1;
        top_id  = IDW'(i);
      end
    end
  end

  wire [63:0] top_val = (64'(top_id) << 16) | 64'(top_id);

  wire [31:0]     base       = req_wide_i ? 32'(wnum) * 32'd64 : 32'(wnum) * 32'd32;
  wire [63:0]     lane_mask  = req_wide_i ? req_wmask_i : {32'b0, req_wmask_i[31:0]};
  wire [NIDS-1:0] wmask_full = (NIDS'(lane_mask) << base) & ~NIDS'(1);
  wire [NIDS-1:0] wdata_full = NIDS'(req_wdata_i) << base;
  wire [NIDS-1:0] word_src   = is_pend ? cur_pend : cur_en;
  wire [63:0]     word_raw   = 64'(word_src >> base);
  wire [63:0]     word_rd    = req_wide_i ? word_raw : {32'b0, word_raw[31:0]};
  wire [NIDS-1:0] word_new   = (word_src & ~wmask_full) | (wdata_full & wmask_full);

  wire [THR_W-1:0] thr_new = (cur_thr & ~req_wmask_i[THR_W-1:0]) |
                             (req_wdata_i[THR_W-1:0] & req_wmask_i[THR_W-1:0]);

  logic [63:0] rd_val;
  always_comb begin
    if (is_deliv)    rd_val = 64'(deliv_q[page]);
    else if (is_thr) rd_val = 64'(cur_thr);
    else if (is_top) rd_val = top_val;
    else             rd_val = word_rd;
  end

  wire do_acc = req_valid_i & acc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_m_q    <= mode_m_i;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
      deliv_q     <= '0;
      for (int p = 0; p < NPAGES; p++) begin
        pend_q[p] <= '0;
        en_q[p]   <= '0;
        thr_q[p]  <= '0;
      end
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i & ~acc_ok;
      rsp_rdata_o <= do_acc ? rd_val : '0;
      if (do_acc) begin
        if (is_deliv && req_wmask_i[0]) deliv_q[page] <= req_wdata_i[0];
        if (is_thr) thr_q[page] <= thr_new;
        if (is_top && top_hit && req_wmask_i != '0) pend_q[page][top_id] <= 1'b0;
        if (is_pend) pend_q[page] <= word_new;
        if (is_en) en_q[page] <= word_new;
      end
    end
  end
endmodule

// File: rtl/irf_indirect_access_chk.sv
module irf_indirect_access_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_m_q,
  input logic        req_valid_i,
  input logic [1:0]  req_priv_i,
  input logic        req_virt_i,
  input logic [7:0]  req_sel_i,
  input logic        req_wide_i,
  input logic        rsp_valid_o,
  input logic [63:0] rsp_rdata_o,
  input logic        rsp_err_o
);
  assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_valid_i));

  assert_err_only_on_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_o |-> rsp_valid_o);

  assert_err_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_o |-> rsp_rdata_o == 64'd0);

  assert_mmode_virt_rejected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_m_q && req_virt_i) |=> rsp_err_o);

  assert_user_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_priv_i == 2'd0) |=> rsp_err_o);

  assert_bad_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_sel_i[7] && req_sel_i != 8'h70 && req_sel_i != 8'h72 &&
     req_sel_i != 8'h7F) |=> rsp_err_o);

  assert_odd_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_wide_i && req_sel_i[7] && req_sel_i[0]) |=> rsp_err_o);

  assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_wide_i) |=> rsp_rdata_o[63:32] == 32'd0);
endmodule

bind irf_indirect_access irf_indirect_access_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_m_q(mode_m_q), .req_valid_i(req_valid_i),
  .req_priv_i(req_priv_i), .req_virt_i(req_virt_i), .req_sel_i(req_sel_i),
  .req_wide_i(req_wide_i), .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
  .rsp_err_o(rsp_err_o)
);

// File: tb/irf_indirect_access_tb.sv
module irf_indirect_access_tb;
  localparam int NP = 4;
  localparam int NI = 128;
  localparam int TW = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_m = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_priv = '0;
  logic        req_virt = 1'b0;
  logic [5:0]  req_gsel = '0;
  logic [7:0]  req_sel = '0;
  logic        req_wide = 1'b0;
  logic [63:0] req_wdata = '0;
  logic [63:0] req_wmask = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        rsp_err;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  irf_indirect_access #(.NPAGES(NP), .NIDS(NI), .THR_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_m_i(mode_m), .req_valid_i(req_valid),
    .req_priv_i(req_priv), .req_virt_i(req_virt), .req_gsel_i(req_gsel),
    .req_sel_i(req_sel), .req_wide_i(req_wide), .req_wdata_i(req_wdata),
    .req_wmask_i(req_wmask), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err)
  );

  bit          m_mode;
  bit          m_pend [NP][NI];
  bit          m_en   [NP][NI];
  bit          m_del  [NP];
  bit [TW-1:0] m_thr  [NP];

  logic [63:0] q_data [$];
  logic        q_err  [$];
  string       q_tag  [$];

  task automatic model_clear(input bit mode);
    m_mode = mode;
    for (int p = 0; p < NP; p++) begin
      m_del[p] = 0;
      m_thr[p] = '0;
      for (int i = 0; i < NI; i++) begin
        m_pend[p][i] = 0;
        m_en[p][i] = 0;
      end
    end
  endtask

  task automatic model(input [1:0] pr, input vi, input [5:0] gs, input [7:0] sl,
                       input wd, input [63:0] d, input [63:0] m,
                       output logic [63:0] r, output logic e);
    int page, n, w, base, hit;
    bit ok;
    ok = 0; page = 0; r = '0; e = 1'b0;
    if (m_mode) ok = (pr == 2'd3) && !vi;
    else if (pr == 2'd1) begin
      if (!vi) ok = 1;
      else if (gs != 0 && int'(gs) < NP) begin ok = 1; page = int'(gs); end
    end
    if (!ok) begin e = 1'b1; return; end
    if (sl == 8'h70) begin
      r = 64'(m_del[page]);
      if (m[0]) m_del[page] = d[0];
    end else if (sl == 8'h72) begin
      r = 64'(m_thr[page]);
      m_thr[page] = (m_thr[page] & ~m[TW-1:0]) | (d[TW-1:0] & m[TW-1:0]);
    end else if (sl == 8'h7F) begin
      hit = 0;
      for (int i = 1; i < NI; i++)
        if (hit == 0 && m_pend[page][i] && m_en[page][i] &&
            (m_thr[page] == 0 || i < int'(m_thr[page]))) hit = i;
      r = (64'(hit) << 16) | 64'(hit);
      if (hit != 0 && m != 0) m_pend[page][hit] = 0;
    end else if (sl[7]) begin
      n = int'(sl[5:0]);
      w = wd ? 64 : 32;
      if (wd && n % 2 == 1) begin e = 1'b1; return; end
      if (wd) n = n / 2;
      if (n >= NI / w) begin e = 1'b1; return; end
      base = n * w;
      for (int i = 0; i < w; i++) begin
        r[i] = sl[6] ? m_en[page][base+i] : m_pend[page][base+i];
        if (m[i] && base + i != 0) begin
          if (sl[6]) m_en[page][base+i] = d[i];
          else m_pend[page][base+i] = d[i];
        end
      end
    end else begin
      e = 1'b1;
    end
  endtask

  task automatic drive(input [1:0] pr, input vi, input [5:0] gs, input [7:0] sl,
                       input wd, input [63:0] d, input [63:0] m, input string tag);
    logic [63:0] er;
    logic ee;
    @(negedge clk);
    req_valid = 1'b1; req_priv = pr; req_virt = vi; req_gsel = gs;
    req_sel = sl; req_wide = wd; req_wdata = d; req_wmask = m;
    model(pr, vi, gs, sl, wd, d, m, er, ee);
    q_data.push_back(er);
    q_err.push_back(ee);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    mode_m = mode;
    model_clear(mode);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compared++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_rdata !== 64'd0) begin
      mismatched++;
      $display("FAIL R11 after reset: valid=%b err=%b data=%h expected 0/0/0",
               rsp_valid, rsp_err, rsp_rdata);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      compared++;
      if (q_tag.size() == 0) begin
        mismatched++;
        $display("FAIL R10 response without request: data=%h err=%b expected none",
                 rsp_rdata, rsp_err);
      end else begin
        logic [63:0] xd;
        logic xe;
        string tg;
        xd = q_data.pop_front();
        xe = q_err.pop_front();
        tg = q_tag.pop_front();
        if (rsp_rdata !== xd || rsp_err !== xe) begin
          mismatched++;
          $display("FAIL %s: data=%h err=%b expected data=%h err=%b",
                   tg, rsp_rdata, rsp_err, xd, xe);
        end
      end
    end
  end

  initial begin
    #2000000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    drive(2'd3, 0, 0, 8'h70, 0, 64'd1, 64'd1, "R1 machine delivery write");
    drive(2'd3, 0, 0, 8'h70, 0, 64'd0, 64'd0, "R7 machine delivery readback");
    drive(2'd3, 1, 1, 8'h70, 0, 64'd0, 64'd1, "R1 machine virt rejected");
    drive(2'd1, 0, 0, 8'h70, 0, 64'd0, 64'd1, "R1 supervisor in machine mode rejected");
    drive(2'd3, 0, 0, 8'h80, 0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R6 machine pend word0 write");
    drive(2'd3, 0, 0, 8'h80, 0, 64'd0, 64'd0, "R6 id0 stays clear");
    idle(3);

    do_reset(1'b0);
    drive(2'd1, 0, 0, 8'h70, 0, 64'd0, 64'd0, "R11 delivery cleared");
    drive(2'd1, 0, 0, 8'h80, 0, 64'h0220, 64'hFFFF_FFFF, "R6 pend ids 5 and 9");
    drive(2'd1, 0, 0, 8'hC0, 0, 64'h0220, 64'hFFFF_FFFF, "R6 enable ids 5 and 9");
    drive(2'd1, 0, 0, 8'h7F, 0, 64'd0, 64'd0, "R8 top read lowest");
    drive(2'd1, 0, 0, 8'h72, 0, 64'd5, 64'hFFFF, "R7 threshold 5");
    drive(2'd1, 0, 0, 8'h7F, 0, 64'd0, 64'd0, "R8 threshold equal blocks");
    drive(2'd1, 0, 0, 8'h72, 0, 64'd6, 64'hFFFF, "R7 threshold 6");
    drive(2'd1, 0, 0, 8'h7F, 0, 64'd0, 64'd0, "R8 threshold above passes");
    drive(2'd1, 0, 0, 8'h72, 0, 64'd0, 64'hFFFF, "R7 threshold cleared");
    drive(2'd1, 0, 0, 8'h7F, 0, 64'd0, 64'd1, "R9 claim returns old");
    drive(2'd1, 0, 0, 8'h7F, 0, 64'd0, 64'd0, "R9 next after claim");
    drive(2'd1, 0, 0, 8'h80, 0, 64'd0, 64'd0, "R9 claimed bit cleared");
    drive(2'd1, 1, 2, 8'hC2, 1, 64'hDEAD_BEEF_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, "R2 guest page wide write");
    drive(2'd1, 1, 2, 8'hC2, 1, 64'd0, 64'd0, "R5 wide readback");
    drive(2'd1, 1, 2, 8'hC2, 0, 64'd0, 64'd0, "R5 narrow low half");
    drive(2'd1, 1, 2, 8'hC3, 0, 64'd0, 64'd0, "R5 narrow high half");
    drive(2'd1, 1, 2, 8'h80, 0, 64'd0, 64'd0, "R2 guest page independent");
    drive(2'd1, 0, 0, 8'hC2, 1, 64'd0, 64'd0, "R2 page0 untouched by guest");
    drive(2'd1, 1, 0, 8'h70, 0, 64'd1, 64'd1, "R2 guest index zero");
    drive(2'd1, 1, 6'(NP), 8'h70, 0, 64'd1, 64'd1, "R2 guest index at count");
    drive(2'd1, 1, 6'(NP-1), 8'h70, 0, 64'd1, 64'd1, "R2 guest index last");
    drive(2'd0, 0, 0, 8'h70, 0, 64'd1, 64'd1, "R2 user rejected");
    drive(2'd3, 0, 0, 8'h70, 0, 64'd1, 64'd1, "R2 machine in supervisor mode rejected");
    drive(2'd1, 0, 0, 8'h71, 0, 64'd0, 64'd0, "R3 select 0x71");
    drive(2'd1, 0, 0, 8'h00, 0, 64'd0, 64'd0, "R3 select 0x00");
    drive(2'd1, 0, 0, 8'h7E, 0, 64'd0, 64'd0, "R3 select 0x7E");
    drive(2'd1, 0, 0, 8'hC1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R4 odd wide index");
    drive(2'd1, 0, 0, 8'hC0, 1, 64'd0, 64'd0, "R10 rejected write left state");
    drive(2'd1, 0, 0, 8'h84, 0, 64'd1, 64'd1, "R4 narrow word past end");
    drive(2'd1, 0, 0, 8'h84, 1, 64'd1, 64'd1, "R4 wide word past end");
    drive(2'd1, 0, 0, 8'h83, 0, 64'h8000_0000, 64'h8000_0000, "R4 last narrow word");
    drive(2'd1, 0, 0, 8'h82, 1, 64'd0, 64'd0, "R4 last narrow word readback");
    drive(2'd1, 0, 0, 8'h80, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0003, "R6 wide partial mask");
    drive(2'd1, 0, 0, 8'h80, 1, 64'd0, 64'd0, "R6 wide partial readback");
    drive(2'd1, 0, 0, 8'h80, 0, 64'd0, 64'hFFFF_FFFF_0000_0000, "R6 narrow ignores upper mask");
    drive(2'd1, 0, 0, 8'h80, 1, 64'd0, 64'd0, "R6 upper mask had no effect");
    drive(2'd1, 0, 0, 8'h72, 0, 64'hFFFF, 64'hFFFF, "R7 threshold width");
    drive(2'd1, 0, 0, 8'h72, 0, 64'd0, 64'd0, "R7 threshold readback");
    drive(2'd1, 0, 0, 8'h70, 0, 64'd1, 64'd2, "R7 delivery mask bit0 clear");
    drive(2'd1, 0, 0, 8'h70, 0, 64'd0, 64'd0, "R7 delivery unchanged");
    idle(4);

    compared++;
    if (q_tag.size() != 0) begin
      mismatched++;
      $display("FAIL R10 missing responses: %0d outstanding expected 0", q_tag.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule